// File: doc/BRIEF.md
# Single-Byte Memory-Mapped Serial Port

This block is a bus-attached asynchronous serial port with one byte of storage in each direction. Software reaches it through five 32-bit word registers on a simple synchronous register bus. The registers are a data window, a status word, a control word, a pending-interrupt word and a bit-period divisor. Frames are fixed at one start bit, eight data bits sent least significant bit first, and one stop bit. There is no parity and no flow control.

A byte written to the data window waits in a transmit holding register. When transmission is enabled and the transmit shifter is idle, the byte moves into the shifter. The receiver waits for a falling edge on the line and samples in the middle of each bit. It places each good frame in the receive holding register. Three interrupt outputs are provided: transmit, receive, and one shared by both overrun conditions. Each output is its pending flag gated by an enable bit in the control word. Pending flags are cleared by writing ones to the pending-interrupt word.

Top module: `uart_mmio`

## Requirements
- R1: Registers are decoded from the byte address with bits 1:0 zero: 0x00 data, 0x04 status, 0x08 control, 0x0C pending interrupts, 0x10 divisor. Control bits 5:0 are writable and read back, and higher bits read 0. The divisor is bits 20:0, and higher written bits are discarded. Other addresses read 0. Read data is combinational from the address while the read strobe is high.
- R2: After reset, status, control and pending interrupts all read 0, the divisor reads 16, the serial output is high, and all three interrupt outputs are low.
- R3: A transmitted frame is a low start bit, then eight data bits with bit 0 first, then a high stop bit. While idle the line is high.
- R4: Every serial bit, transmitted or received, lasts the divisor value in clock cycles. A divisor write below 16 stores 16.
- R5: Status bit 0 is 1 while the transmit holding byte is occupied. Writing data while status bit 0 is 1 drops the new byte and sets status bit 2 and pending bit 2 (transmit overrun).
- R6: Pending bit 0 sets when the holding byte moves into the transmit shifter. The transmit interrupt output is pending bit 0 AND control bit 2.
- R7: A complete good frame sets status bit 1 and pending bit 1. The receive interrupt output is pending bit 1 AND control bit 3. A data read returns the byte and clears status bit 1.
- R8: A good frame that arrives while status bit 1 is set keeps the old byte and sets status bit 3 and pending bit 3 (receive overrun).
- R9: A frame whose stop bit samples low is discarded and sets no flag.
- R10: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. Status bits 2 and 3 mirror pending bits 2 and 3.
- R11: The overrun interrupt output is (pending bit 2 AND control bit 4) OR (pending bit 3 AND control bit 5).
- R12: Control bit 0 enables transmission and control bit 1 enables reception. With transmission off, the held byte stays held and the line stays high. With reception off, no new frame is started. Clearing either enable takes effect at a frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | BUS_W | Write data |
| bus_rd | input | 1 | Read strobe (a data read consumes the received byte) |
| bus_rdata | output | BUS_W | Read data |
| ser_rx | input | 1 | Serial input line |
| ser_tx | output | 1 | Serial output line |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_ovr | output | 1 | Combined overrun interrupt |

## Verification
The transmit overrun is the hardest case to reach from the ports. With transmission enabled, the holding byte drains into the shifter one cycle after it is written, so a second write rarely finds the buffer full. The stimulus therefore writes two bytes with the transmit enable cleared. The first byte stays held, and the second byte is the overrun. The bench then enables transmission and checks that the line carries the first byte. The receive overrun is reached by sending two full frames without reading the data window between them.

// File: rtl/uart_mmio_pkg.sv
package uart_mmio_pkg;

    localparam int DIV_W    = 21;
    localparam int BYTE_W   = 8;
    localparam int CTRL_W   = 6;
    localparam int FLAG_W   = 4;
    localparam int BITCNT_W = $clog2(BYTE_W);

    localparam logic [2:0] W_DATA = 3'd0;
    localparam logic [2:0] W_STAT = 3'd1;
    localparam logic [2:0] W_CTRL = 3'd2;
    localparam logic [2:0] W_PEND = 3'd3;
    localparam logic [2:0] W_DIV  = 3'd4;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_STOP
    } phase_e;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [DIV_W-1:0]  div;
        logic [BYTE_W-1:0] tx_buf;
        logic              tx_full;
        logic [BYTE_W-1:0] rx_buf;
        logic              rx_full;
        logic [FLAG_W-1:0] flags;
    } regs_t;

endpackage

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
    import uart_mmio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic [DIV_W-1:0]  divisor,
    output logic              txd,
    output logic              busy
);

    typedef struct packed {
        phase_e              phase;
        logic [DIV_W-1:0]    cnt;
        logic [BITCNT_W-1:0] bitn;
        logic [BYTE_W-1:0]   shreg;
        logic                line;
    } tx_st_t;

    tx_st_t q, d;
    logic   bit_end;

    always_comb begin
        d       = q;
        bit_end = (q.cnt >= divisor - 1'b1);
        if (q.phase != PH_IDLE) begin
            d.cnt = bit_end ? '0 : q.cnt + 1'b1;
        end
        unique case (q.phase)
            PH_IDLE: begin
                d.line = 1'b1;
                if (load) begin
                    d.phase = PH_START;
                    d.cnt   = '0;
                    d.shreg = load_byte;
                    d.line  = 1'b0;
                end
            end
            PH_START: begin
                if (bit_end) begin
                    d.phase = PH_DATA;
                    d.bitn  = '0;
                    d.line  = q.shreg[0];
                end
            end
            PH_DATA: begin
                if (bit_end) begin
                    if (q.bitn == BITCNT_W'(BYTE_W - 1)) begin
                        d.phase = PH_STOP;
                        d.line  = 1'b1;
                    end else begin
                        d.bitn  = q.bitn + 1'b1;
                        d.shreg = {1'b0, q.shreg[BYTE_W-1:1]};
                        d.line  = q.shreg[1];
                    end
                end
            end
            PH_STOP: begin
                if (bit_end) begin
                    d.phase = PH_IDLE;
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, cnt: '0, bitn: '0, shreg: '0, line: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign txd  = q.line;
    assign busy = (q.phase != PH_IDLE);

endmodule

// File: rtl/uart_rx_shift.sv
module uart_rx_shift
    import uart_mmio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              enable,
    input  logic [DIV_W-1:0]  divisor,
    output logic              frame_ok,
    output logic [BYTE_W-1:0] frame_byte
);

    typedef struct packed {
        logic [2:0]          sync;
        phase_e              phase;
        logic [DIV_W-1:0]    cnt;
        logic [BITCNT_W-1:0] bitn;
        logic [BYTE_W-1:0]   shreg;
        logic                done;
        logic [BYTE_W-1:0]   byte_out;
    } rx_st_t;

    rx_st_t           q, d;
    logic             cur, prev, bit_end, half_end;
    logic [DIV_W-1:0] half;

    always_comb begin
        d        = q;
        d.sync   = {q.sync[1:0], rxd};
        d.done   = 1'b0;
        cur      = q.sync[1];
        prev     = q.sync[2];
        half     = divisor >> 1;
        bit_end  = (q.cnt >= divisor - 1'b1);
        half_end = (q.cnt >= half - 1'b1);
        unique case (q.phase)
            PH_IDLE: begin
                if (enable && prev && !cur) begin
                    d.phase = PH_START;
                    d.cnt   = '0;
                end
            end
            PH_START: begin
                if (half_end) begin
                    d.cnt   = '0;
                    d.bitn  = '0;
                    d.phase = cur ? PH_IDLE : PH_DATA;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PH_DATA: begin
                if (bit_end) begin
                    d.cnt   = '0;
                    d.shreg = {cur, q.shreg[BYTE_W-1:1]};
                    if (q.bitn == BITCNT_W'(BYTE_W - 1)) begin
                        d.phase = PH_STOP;
                    end else begin
                        d.bitn = q.bitn + 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PH_STOP: begin
                if (bit_end) begin
                    d.cnt   = '0;
                    d.phase = PH_IDLE;
                    if (cur) begin
                        d.done     = 1'b1;
                        d.byte_out = q.shreg;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sync: 3'b111, phase: PH_IDLE, cnt: '0, bitn: '0,
                   shreg: '0, done: 1'b0, byte_out: '0};
        end else begin
            q <= d;
        end
    end

    assign frame_ok   = q.done;
    assign frame_byte = q.byte_out;

endmodule

// File: rtl/uart_mmio.sv
module uart_mmio
    import uart_mmio_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int BUS_W     = 32,
    parameter int MIN_DIV   = 16,
    parameter int RESET_DIV = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              ser_rx,
    output logic              ser_tx,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_ovr
);

    localparam int WORD_W = ADDR_W - 2;

    regs_t             q, d;
    logic              tx_busy, tx_load;
    logic              rx_ok;
    logic [BYTE_W-1:0] rx_byte;
    logic              hit;
    logic [WORD_W-1:0] word;
    logic              wr_data, wr_ctrl, wr_pend, wr_div, rd_take;
    logic [FLAG_W-1:0] clr_mask, set_mask;
    logic              rx_busy_eff;
    wire               unused_hi = ^bus_wdata[BUS_W-1:DIV_W];

    assign hit     = (bus_addr[1:0] == 2'b00);
    assign word    = bus_addr[ADDR_W-1:2];
    assign wr_data = bus_wr && hit && (word == WORD_W'(W_DATA));
    assign wr_ctrl = bus_wr && hit && (word == WORD_W'(W_CTRL));
    assign wr_pend = bus_wr && hit && (word == WORD_W'(W_PEND));
    assign wr_div  = bus_wr && hit && (word == WORD_W'(W_DIV));
    assign rd_take = bus_rd && hit && (word == WORD_W'(W_DATA)) && q.rx_full;
    assign tx_load = q.ctrl[0] && q.tx_full && !tx_busy;

    always_comb begin
        d           = q;
        set_mask    = '0;
        clr_mask    = wr_pend ? bus_wdata[FLAG_W-1:0] : '0;
        rx_busy_eff = q.rx_full && !rd_take;

        if (tx_load) begin
            d.tx_full   = 1'b0;
            set_mask[0] = 1'b1;
        end
        if (wr_data) begin
            if (q.tx_full) begin
                set_mask[2] = 1'b1;
            end else begin
                d.tx_buf  = bus_wdata[BYTE_W-1:0];
                d.tx_full = 1'b1;
            end
        end
        if (wr_ctrl) begin
            d.ctrl = bus_wdata[CTRL_W-1:0];
        end
        if (wr_div) begin
            d.div = (bus_wdata[DIV_W-1:0] < DIV_W'(MIN_DIV)) ?
                    DIV_W'(MIN_DIV) : bus_wdata[DIV_W-1:0];
        end
        if (rd_take) begin
            d.rx_full = 1'b0;
        end
        if (rx_ok) begin
            if (rx_busy_eff) begin
                set_mask[3] = 1'b1;
            end else begin
                d.rx_buf    = rx_byte;
                d.rx_full   = 1'b1;
                set_mask[1] = 1'b1;
            end
        end
        d.flags = (q.flags & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ctrl: '0, div: DIV_W'(RESET_DIV), tx_buf: '0, tx_full: 1'b0,
                   rx_buf: '0, rx_full: 1'b0, flags: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && hit) begin
            unique case (word)
                WORD_W'(W_DATA): bus_rdata[BYTE_W-1:0] = q.rx_buf;
                WORD_W'(W_STAT): bus_rdata[3:0] = {q.flags[3], q.flags[2], q.rx_full, q.tx_full};
                WORD_W'(W_CTRL): bus_rdata[CTRL_W-1:0] = q.ctrl;
                WORD_W'(W_PEND): bus_rdata[FLAG_W-1:0] = q.flags;
                WORD_W'(W_DIV):  bus_rdata[DIV_W-1:0] = q.div;
                default:         bus_rdata = '0;
            endcase
        end
    end

    assign irq_tx  = q.flags[0] && q.ctrl[2];
    assign irq_rx  = q.flags[1] && q.ctrl[3];
    assign irq_ovr = (q.flags[2] && q.ctrl[4]) || (q.flags[3] && q.ctrl[5]);

    uart_tx_shift u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_load),
        .load_byte (q.tx_buf),
        .divisor   (q.div),
        .txd       (ser_tx),
        .busy      (tx_busy)
    );

    uart_rx_shift u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rxd        (ser_rx),
        .enable     (q.ctrl[1]),
        .divisor    (q.div),
        .frame_ok   (rx_ok),
        .frame_byte (rx_byte)
    );

endmodule

// File: rtl/uart_mmio_chk.sv
module uart_mmio_chk
    import uart_mmio_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int BUS_W   = 32,
    parameter int MIN_DIV = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              ser_tx,
    input logic              tx_busy,
    input logic              tx_full,
    input logic              rx_full,
    input logic [FLAG_W-1:0] flags,
    input logic [DIV_W-1:0]  div
);

    logic wr_pend, wr_data;
    assign wr_pend = bus_wr && (bus_addr == ADDR_W'(12));
    assign wr_data = bus_wr && (bus_addr == ADDR_W'(0));

    // R3: an idle shifter keeps the line high
    a_r3_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> ser_tx);

    // R4: the stored divisor never drops below the floor
    a_r4_div_floor: assert property (@(posedge clk) disable iff (!rst_n)
        div >= DIV_W'(MIN_DIV));

    // R6: the transmit flag rises only as the holding byte leaves
    a_r6_flag_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> $fell(tx_full));

    // R7: a newly filled receive buffer has its flag pending
    a_r7_rx_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> flags[1]);

    // R5: a data write into a full buffer raises transmit overrun
    a_r5_ovr_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && tx_full) |=> flags[2]);

    // R10: writing 1 to pending bit 2 clears it
    a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pend && bus_wdata[2]) |=> !flags[2]);

endmodule

bind uart_mmio uart_mmio_chk #(
    .ADDR_W  (ADDR_W),
    .BUS_W   (BUS_W),
    .MIN_DIV (MIN_DIV)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .ser_tx    (ser_tx),
    .tx_busy   (tx_busy),
    .tx_full   (q.tx_full),
    .rx_full   (q.rx_full),
    .flags     (q.flags),
    .div       (q.div)
);

// File: tb/uart_mmio_bench.sv
module uart_mmio_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] A_DATA = 5'h00, A_STAT = 5'h04, A_CTRL = 5'h08,
                           A_PEND = 5'h0C, A_DIV = 5'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        ser_rx = 1'b1;
    logic        ser_tx, irq_tx, irq_rx, irq_ovr;

    int total = 0;
    int bad = 0;
    int cur_div = 16;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_mmio u_uart_mmio (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .ser_rx(ser_rx), .ser_tx(ser_tx), .irq_tx(irq_tx), .irq_rx(irq_rx),
        .irq_ovr(irq_ovr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    // watch the line for one frame at cur_div cycles per bit
    task automatic watch_frame(input string req, input logic [7:0] exp);
        int waited = 0;
        logic [7:0] got = '0;
        while (ser_tx === 1'b1 && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        if (waited >= 2000) begin
            chk({req, " start"}, 32'(ser_tx), 32'd0);
            return;
        end
        repeat (cur_div/2) @(negedge clk);
        chk({req, " start bit"}, 32'(ser_tx), 32'd0);
        for (int i = 0; i < 8; i++) begin
            repeat (cur_div) @(negedge clk);
            got[i] = ser_tx;
        end
        chk({req, " data"}, 32'(got), 32'(exp));
        repeat (cur_div) @(negedge clk);
        chk({req, " stop bit"}, 32'(ser_tx), 32'd1);
        repeat (cur_div) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input logic stop);
        @(negedge clk);
        ser_rx = 1'b0;
        repeat (cur_div) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            ser_rx = b[i];
            repeat (cur_div) @(negedge clk);
        end
        ser_rx = stop;
        repeat (cur_div) @(negedge clk);
        ser_rx = 1'b1;
        repeat (2*cur_div) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R2 ser_tx", 32'(ser_tx), 32'd1);
        chk("R2 irqs", 32'({irq_tx, irq_rx, irq_ovr}), 32'd0);
        rd_chk("R2 status", A_STAT, 32'd0);
        rd_chk("R2 control", A_CTRL, 32'd0);
        rd_chk("R2 pending", A_PEND, 32'd0);
        rd_chk("R2 divisor", A_DIV, 32'd16);
        rd_chk("R1 unmapped", 5'h14, 32'd0);
    endtask

    task automatic t_regs;
        wr(A_DIV, 32'd5);
        rd_chk("R4 divisor floor", A_DIV, 32'd16);
        wr(A_DIV, 32'hFFFF_FFFF);
        rd_chk("R1 divisor width", A_DIV, 32'h001F_FFFF);
        wr(A_DIV, 32'd16);
        wr(A_CTRL, 32'hFFFF);
        rd_chk("R1 control width", A_CTRL, 32'h3F);
        wr(A_CTRL, 32'd0);
    endtask

    task automatic t_tx_basic;
        wr(A_CTRL, 32'h05);
        wr(A_DATA, 32'hA5);
        watch_frame("R3 frame A5", 8'hA5);
        chk("R6 irq_tx set", 32'(irq_tx), 32'd1);
        rd_chk("R6 pending bit0", A_PEND, 32'h1);
        wr(A_PEND, 32'h0);
        rd_chk("R10 write0 keeps", A_PEND, 32'h1);
        wr(A_PEND, 32'h1);
        chk("R10 irq_tx cleared", 32'(irq_tx), 32'd0);
        rd_chk("R10 pending cleared", A_PEND, 32'h0);
    endtask

    task automatic t_tx_overrun;
        int lows = 0;
        wr(A_CTRL, 32'h10);
        wr(A_DATA, 32'h3C);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (ser_tx !== 1'b1) lows++;
        end
        chk("R12 line held high", 32'(lows), 32'd0);
        rd_chk("R5 full bit", A_STAT, 32'h1);
        chk("R11 irq_ovr quiet", 32'(irq_ovr), 32'd0);
        wr(A_DATA, 32'h77);
        rd_chk("R5 overrun status", A_STAT, 32'h5);
        rd_chk("R5 overrun pending", A_PEND, 32'h4);
        chk("R11 irq_ovr tx", 32'(irq_ovr), 32'd1);
        wr(A_PEND, 32'h4);
        chk("R10 irq_ovr cleared", 32'(irq_ovr), 32'd0);
        wr(A_CTRL, 32'h11);
        watch_frame("R5 first byte kept", 8'h3C);
        rd_chk("R5 empty after send", A_STAT, 32'h0);
        wr(A_PEND, 32'hF);
    endtask

    task automatic t_tx_div;
        wr(A_DIV, 32'd24);
        cur_div = 24;
        wr(A_CTRL, 32'h01);
        wr(A_DATA, 32'h5A);
        watch_frame("R4 div 24 frame", 8'h5A);
        wr(A_DIV, 32'd16);
        cur_div = 16;
        wr(A_PEND, 32'hF);
    endtask

    task automatic t_rx_basic;
        logic [31:0] v;
        wr(A_CTRL, 32'h0A);
        send(8'hC3, 1'b1);
        rd_chk("R7 rx full", A_STAT, 32'h2);
        chk("R7 irq_rx", 32'(irq_rx), 32'd1);
        rd(A_DATA, v);
        chk("R7 data", v, 32'hC3);
        rd_chk("R7 full cleared", A_STAT, 32'h0);
        wr(A_PEND, 32'h2);
        chk("R10 irq_rx cleared", 32'(irq_rx), 32'd0);
    endtask

    task automatic t_rx_overrun;
        logic [31:0] v;
        wr(A_CTRL, 32'h22);
        send(8'h11, 1'b1);
        chk("R11 irq_ovr before", 32'(irq_ovr), 32'd0);
        send(8'h22, 1'b1);
        rd_chk("R8 status", A_STAT, 32'hA);
        chk("R11 irq_ovr rx", 32'(irq_ovr), 32'd1);
        rd(A_DATA, v);
        chk("R8 old byte kept", v, 32'h11);
        wr(A_PEND, 32'hF);
        rd_chk("R10 all cleared", A_PEND, 32'h0);
    endtask

    task automatic t_rx_badstop;
        logic [31:0] v;
        wr(A_CTRL, 32'h02);
        send(8'h99, 1'b0);
        rd_chk("R9 no full", A_STAT, 32'h0);
        rd_chk("R9 no pending", A_PEND, 32'h0);
        send(8'h42, 1'b1);
        rd(A_DATA, v);
        chk("R9 recovery byte", v, 32'h42);
        wr(A_PEND, 32'hF);
    endtask

    task automatic t_rx_disabled;
        wr(A_CTRL, 32'h00);
        send(8'h55, 1'b1);
        rd_chk("R12 rx off", A_STAT, 32'h0);
        rd_chk("R12 rx off pending", A_PEND, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_tx_basic();
        t_tx_overrun();
        t_tx_div();
        t_rx_basic();
        t_rx_overrun();
        t_rx_badstop();
        t_rx_disabled();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule